// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

The block gathers up to sixty-four active-low interrupt inputs into two 32-bit banks, called high and low. Source numbers do not map to bit positions by simple arithmetic. A fixed lookup places each source at one bank and one bit. Each bank has a mask register and a pending register. A vector register reports the lowest-numbered source that is both pending and enabled, and a single interrupt output tells the processor that at least one such source exists.

Most sources are internal and always sensed as an active-low level. Seven external sources (19 to 25) can be switched to falling-edge sensing. Sixteen port sources (48 to 63) can be set to falling-edge or to both-edge sensing. The sense choices live in one 32-bit edge-select register. Every input passes through a two-stage synchronizer before it is sensed.

Software reaches the registers through a 32-bit word port. Writes take effect on the rising clock edge. Reads are combinational from the word address.

Top module: `irq_bank64_ctrl`

## Requirements
- R1: After reset, both mask registers, both pending registers and the edge-select register read 0, the vector reads 0 and irq_o is low.
- R2: Word addresses are 0 high mask, 1 low mask, 2 high pending, 3 low pending, 4 vector (read only, writes ignored) and 5 edge select. The mask and edge-select registers read back what was written. Addresses 6 and 7 read 0, and writes to them change nothing.
- R3: Low bank mapping: source 0 uses bit 0, sources 1 to 15 use bits 15 down to 1, and sources 32 to 47 use bits 31 down to 16.
- R4: High bank mapping: sources 16, 17 and 18 use bits 2, 1 and 0. Sources 19 to 30 use bits 14 down to 3. Source 31 also uses bit 0, so it shares that bit with source 18, and the vector reports 18 for it. Sources 48 to 63 use bits 16 up to 31.
- R5: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. A sense event in the same cycle wins over the clear.
- R6: An internal source sets its pending bit on every cycle its input is low, whatever the edge-select register holds. After the input returns high the bit stays set until it is cleared.
- R7: External source s (19 to 25) is controlled by edge-select bit 33-s. With that bit at 1 only a falling edge sets pending, and a held-low input does not set it again after a clear. With the bit at 0 the source is sensed as an active-low level.
- R8: Port source s (48 to 63) is controlled by edge-select bit s-32. With that bit at 1 only a falling edge sets pending. With the bit at 0 both falling and rising edges set it.
- R9: A change on a source input first shows in the pending register after the third rising clock edge that follows it.
- R10: The vector reads (source number << 26), with all other bits 0, for the lowest source whose pending and mask bits are both 1. It reads 0 when there is no such source.
- R11: irq_o is high exactly when some pending bit has its mask bit set. Masking does not stop a pending bit from being set or kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_n_i | input | 64 | Interrupt source inputs, active low, index = source number |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong lookup entry puts the pending flag in the wrong bank or bit. That shows in the pending register three edges after the input falls, and it also changes the vector, because the winner is chosen by source number. A sense-class fault shows as a bit that either comes back or stays clear one edge after a write-one clear while the input is still held low. A stale or dropped clear shows at once on the next pending read and on irq_o. A priority fault shows as soon as two enabled sources are pending together.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int NSRC    = 64;
  localparam int BANK_W  = 32;
  localparam int BIT_W   = $clog2(BANK_W);
  localparam int VEC_W   = $clog2(NSRC);
  localparam int VEC_LSB = BANK_W - VEC_W;

  typedef enum logic [1:0] {
    SNS_LEVEL = 2'd0,
    SNS_EXT   = 2'd1,
    SNS_PORT  = 2'd2
  } sense_cls_e;

  typedef enum logic [2:0] {
    RA_MASK_HI = 3'd0,
    RA_MASK_LO = 3'd1,
    RA_PEND_HI = 3'd2,
    RA_PEND_LO = 3'd3,
    RA_VECTOR  = 3'd4,
    RA_ESEL    = 3'd5
  } reg_addr_e;

  // 1 when the source lives in the high bank
  function automatic logic src_in_hi(input int unsigned s);
    return ((s >= 16) && (s < 32)) || (s >= 48);
  endfunction

  // bit position inside its bank
  function automatic logic [BIT_W-1:0] src_bit(input int unsigned s);
    int unsigned b;
    if (s == 0)       b = 0;
    else if (s < 16)  b = 16 - s;
    else if (s < 19)  b = 18 - s;
    else if (s < 31)  b = 33 - s;
    else if (s == 31) b = 0;
    else if (s < 48)  b = 63 - s;
    else              b = s - 32;
    return BIT_W'(b);
  endfunction

  function automatic sense_cls_e src_class(input int unsigned s);
    if ((s >= 19) && (s <= 25)) return SNS_EXT;
    if (s >= 48)                return SNS_PORT;
    return SNS_LEVEL;
  endfunction

  // edge-select bit governing an external or port source
  function automatic logic [BIT_W-1:0] esel_bit(input int unsigned s);
    if (s >= 48) return BIT_W'(s - 32);
    return BIT_W'(33 - s);
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] cur_n,
  output logic [W-1:0] prev_n
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '1;
          else        chain[g] <= d_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= chain[STAGES-1];
  end

  assign cur_n = chain[STAGES-1];
endmodule

// File: rtl/irqc_sense.sv
module irqc_sense
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0]   cur_n,
  input  logic [NSRC-1:0]   prev_n,
  input  logic [BANK_W-1:0] esel,
  output logic [NSRC-1:0]   fire,
  output logic [BANK_W-1:0] set_hi,
  output logic [BANK_W-1:0] set_lo
);
  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      localparam sense_cls_e CLS = src_class(s);
      localparam int unsigned EB = esel_bit(s);
      logic fall, rise;
      assign fall = prev_n[s] & ~cur_n[s];
      assign rise = ~prev_n[s] & cur_n[s];
      if (CLS == SNS_EXT) begin : g_ext
        assign fire[s] = esel[EB] ? fall : ~cur_n[s];
      end else if (CLS == SNS_PORT) begin : g_port
        assign fire[s] = esel[EB] ? fall : (fall | rise);
      end else begin : g_lvl
        assign fire[s] = ~cur_n[s];
      end
    end
  endgenerate

  // fold source events into bank bit positions
  always_comb begin
    set_hi = '0;
    set_lo = '0;
    for (int unsigned k = 0; k < NSRC; k++) begin
      if (src_in_hi(k)) set_hi[src_bit(k)] = set_hi[src_bit(k)] | fire[k];
      else              set_lo[src_bit(k)] = set_lo[src_bit(k)] | fire[k];
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [BANK_W-1:0] pend_hi,
  input  logic [BANK_W-1:0] pend_lo,
  input  logic [BANK_W-1:0] mask_hi,
  input  logic [BANK_W-1:0] mask_lo,
  output logic [VEC_W-1:0]  vec_src,
  output logic              any
);
  logic [BANK_W-1:0] act_hi, act_lo;
  assign act_hi = pend_hi & mask_hi;
  assign act_lo = pend_lo & mask_lo;
  assign any    = |{act_hi, act_lo};

  // scan downward so the lowest active source is the last one written
  always_comb begin
    vec_src = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (src_in_hi(k) ? act_hi[src_bit(k)] : act_lo[src_bit(k)])
        vec_src = VEC_W'(k);
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] set_hi,
  input  logic [BANK_W-1:0] set_lo,
  input  logic [VEC_W-1:0]  vec_src,
  output logic [BANK_W-1:0] mask_hi,
  output logic [BANK_W-1:0] mask_lo,
  output logic [BANK_W-1:0] pend_hi,
  output logic [BANK_W-1:0] pend_lo,
  output logic [BANK_W-1:0] esel,
  output logic [BANK_W-1:0] clr_hi,
  output logic [BANK_W-1:0] clr_lo,
  output logic [BANK_W-1:0] rdata
);
  logic hit_mhi, hit_mlo, hit_phi, hit_plo, hit_esel;
  assign hit_mhi  = wr_en && (addr == ADDR_W'(RA_MASK_HI));
  assign hit_mlo  = wr_en && (addr == ADDR_W'(RA_MASK_LO));
  assign hit_phi  = wr_en && (addr == ADDR_W'(RA_PEND_HI));
  assign hit_plo  = wr_en && (addr == ADDR_W'(RA_PEND_LO));
  assign hit_esel = wr_en && (addr == ADDR_W'(RA_ESEL));

  assign clr_hi = hit_phi ? wdata : '0;
  assign clr_lo = hit_plo ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi <= '0;
      mask_lo <= '0;
      esel    <= '0;
    end else begin
      if (hit_mhi)  mask_hi <= wdata;
      if (hit_mlo)  mask_lo <= wdata;
      if (hit_esel) esel    <= wdata;
    end
  end

  // set wins over a write-one clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi <= '0;
      pend_lo <= '0;
    end else begin
      pend_hi <= (pend_hi & ~clr_hi) | set_hi;
      pend_lo <= (pend_lo & ~clr_lo) | set_lo;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_W'(RA_MASK_HI): rdata = mask_hi;
      ADDR_W'(RA_MASK_LO): rdata = mask_lo;
      ADDR_W'(RA_PEND_HI): rdata = pend_hi;
      ADDR_W'(RA_PEND_LO): rdata = pend_lo;
      ADDR_W'(RA_VECTOR):  rdata = {vec_src, {VEC_LSB{1'b0}}};
      ADDR_W'(RA_ESEL):    rdata = esel;
      default:             rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_bank64_ctrl.sv
module irq_bank64_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0]   cur_n, prev_n, fire;
  logic [BANK_W-1:0] esel, set_hi, set_lo, clr_hi, clr_lo;
  logic [BANK_W-1:0] mask_hi, mask_lo, pend_hi, pend_lo;
  logic [VEC_W-1:0]  vec_src;
  logic              any_act;

  irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_i), .rst_n(rst_ni), .d_n(src_n_i),
    .cur_n(cur_n), .prev_n(prev_n)
  );

  irqc_sense u_sense (
    .cur_n(cur_n), .prev_n(prev_n), .esel(esel),
    .fire(fire), .set_hi(set_hi), .set_lo(set_lo)
  );

  irqc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk_i), .rst_n(rst_ni), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .set_hi(set_hi), .set_lo(set_lo), .vec_src(vec_src),
    .mask_hi(mask_hi), .mask_lo(mask_lo), .pend_hi(pend_hi), .pend_lo(pend_lo),
    .esel(esel), .clr_hi(clr_hi), .clr_lo(clr_lo), .rdata(rdata_o)
  );

  irqc_prio u_prio (
    .pend_hi(pend_hi), .pend_lo(pend_lo), .mask_hi(mask_hi), .mask_lo(mask_lo),
    .vec_src(vec_src), .any(any_act)
  );

  assign irq_o = any_act;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] wdata,
  input logic [BANK_W-1:0] mask_hi,
  input logic [BANK_W-1:0] mask_lo,
  input logic [BANK_W-1:0] pend_hi,
  input logic [BANK_W-1:0] pend_lo,
  input logic [BANK_W-1:0] set_hi,
  input logic [BANK_W-1:0] set_lo,
  input logic [BANK_W-1:0] clr_hi,
  input logic [VEC_W-1:0]  vec_src,
  input logic              irq
);
  logic win_act;
  always_comb begin
    if (src_in_hi(32'(vec_src))) win_act = pend_hi[src_bit(32'(vec_src))] & mask_hi[src_bit(32'(vec_src))];
    else                         win_act = pend_lo[src_bit(32'(vec_src))] & mask_lo[src_bit(32'(vec_src))];
  end

  // R2: mask write lands on the next edge
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(RA_MASK_HI)) |=> (mask_hi == $past(wdata)));

  // R5: write-one clear removes bits not re-set in the same cycle
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hi != '0) |=> ((pend_hi & $past(clr_hi) & ~$past(set_hi)) == '0));

  // R5: a sense event always lands
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_hi & $past(set_hi)) == $past(set_hi)) &&
             ((pend_lo & $past(set_lo)) == $past(set_lo)));

  // R6: with no clear and no event the pending bank holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hi == '0 && set_hi == '0) |=> $stable(pend_hi));

  // R10: the reported winner is really pending and enabled
  a_r10_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> win_act);

  // R11: request line agrees with the vector
  a_r11_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((vec_src != '0) || (pend_lo[0] & mask_lo[0])));
endmodule

bind irq_bank64_ctrl irqc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
  .mask_hi(mask_hi), .mask_lo(mask_lo), .pend_hi(pend_hi), .pend_lo(pend_lo),
  .set_hi(set_hi), .set_lo(set_lo), .clr_hi(clr_hi), .vec_src(vec_src), .irq(irq_o)
);

// File: tb/sim_irq_bank64_ctrl.sv
module sim_irq_bank64_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank64_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_n_i(src_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic bit b_hi(int s);
    return ((s >> 4) & 1) == 1;
  endfunction

  function automatic int b_bit(int s);
    case (s >> 4)
      0: return (s == 0) ? 0 : 16 - s;
      1: return (s < 19) ? 18 - s : ((s == 31) ? 0 : 33 - s);
      2: return 63 - s;
      default: return s - 32;
    endcase
  endfunction

  function automatic logic [31:0] b_vec(logic [31:0] ph, logic [31:0] pl,
                                        logic [31:0] mh, logic [31:0] ml);
    for (int s = 0; s < 64; s++) begin
      if (b_hi(s) ? (ph[b_bit(s)] & mh[b_bit(s)]) : (pl[b_bit(s)] & ml[b_bit(s)]))
        return 32'(s) << 26;
    end
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int s, input logic v);
    @(negedge clk);
    src_n[s] = v;
  endtask

  initial begin
    logic [31:0] d, ph, pl;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    // R2 register access
    wr(3'd0, 32'hA5A5_5A5A); rd(3'd0, d); chk("R2 mask hi readback", d, 32'hA5A5_5A5A);
    wr(3'd1, 32'h0F0F_1234); rd(3'd1, d); chk("R2 mask lo readback", d, 32'h0F0F_1234);
    wr(3'd5, 32'h1357_9BDF); rd(3'd5, d); chk("R2 edge select readback", d, 32'h1357_9BDF);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); chk("R2 vector write ignored", d, 32'd0);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); chk("R2 addr 6 reads zero", d, 32'd0);
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 addr 7 write ignored", d, 32'hA5A5_5A5A);
    wr(3'd5, 32'd0);

    // R9 latency on source 3 (low bit 13)
    drive(3, 1'b0);
    wait_edges(2); rd(3'd3, d); chk("R9 not yet after two edges", d, 32'd0);
    wait_edges(1); rd(3'd3, d); chk("R9 set after third edge", d, 32'h0000_2000);
    drive(3, 1'b1); wait_edges(4); wr(3'd3, 32'hFFFF_FFFF);

    // R3 R4 R10 R11 sweep, all enabled
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    for (int s = 0; s < 64; s++) begin
      drive(s, 1'b0);
      wait_edges(4);
      rd(3'd2, ph); rd(3'd3, pl);
      chk(b_hi(s) ? "R4 high bank map" : "R3 low bank map", ph, b_hi(s) ? (32'd1 << b_bit(s)) : 32'd0);
      chk(b_hi(s) ? "R4 low bank idle" : "R3 low bank map", pl, b_hi(s) ? 32'd0 : (32'd1 << b_bit(s)));
      rd(3'd4, d);
      chk("R10 vector sweep", d, b_vec(ph, pl, 32'hFFFF_FFFF, 32'hFFFF_FFFF));
      chk("R11 irq sweep", {31'd0, irq}, 32'd1);
      drive(s, 1'b1);
      wait_edges(4);
      wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd2, ph); rd(3'd3, pl);
      chk("R5 clear all", ph | pl, 32'd0);
    end

    // R4 shared bit: source 31 reports 18
    drive(31, 1'b0); wait_edges(4);
    rd(3'd4, d); chk("R4 shared bit vector", d, 32'd18 << 26);
    drive(31, 1'b1); wait_edges(4); wr(3'd2, 32'hFFFF_FFFF);

    // R7 external source 20: edge bit 13, high bank bit 13
    wr(3'd5, 32'h0000_2000);
    drive(20, 1'b0); wait_edges(4);
    rd(3'd2, d); chk("R7 falling edge sets", d, 32'h0000_2000);
    wr(3'd2, 32'h0000_2000); wait_edges(2);
    rd(3'd2, d); chk("R7 held low no re-set", d, 32'd0);
    drive(20, 1'b1); wait_edges(4);
    rd(3'd2, d); chk("R7 rising ignored", d, 32'd0);
    wr(3'd5, 32'd0);
    drive(20, 1'b0); wait_edges(4);
    wr(3'd2, 32'h0000_2000);
    rd(3'd2, d); chk("R7 level re-sets after clear", d, 32'h0000_2000);
    drive(20, 1'b1); wait_edges(4); wr(3'd2, 32'hFFFF_FFFF);

    // R8 port source 50: edge bit 18, high bank bit 18
    drive(50, 1'b0); wait_edges(4);
    rd(3'd2, d); chk("R8 both-edge falling", d, 32'h0004_0000);
    wr(3'd2, 32'h0004_0000); wait_edges(2);
    rd(3'd2, d); chk("R8 cleared while low", d, 32'd0);
    drive(50, 1'b1); wait_edges(4);
    rd(3'd2, d); chk("R8 both-edge rising", d, 32'h0004_0000);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd5, 32'h0004_0000);
    drive(50, 1'b0); wait_edges(4);
    rd(3'd2, d); chk("R8 falling-only falling", d, 32'h0004_0000);
    wr(3'd2, 32'hFFFF_FFFF);
    drive(50, 1'b1); wait_edges(4);
    rd(3'd2, d); chk("R8 falling-only rising ignored", d, 32'd0);

    // R6 internal source 5 (low bit 11) ignores edge select
    wr(3'd5, 32'hFFFF_FFFF);
    drive(5, 1'b0); wait_edges(4);
    wr(3'd3, 32'h0000_0800);
    rd(3'd3, d); chk("R6 level re-sets", d, 32'h0000_0800);
    drive(5, 1'b1); wait_edges(4);
    rd(3'd3, d); chk("R6 stays after release", d, 32'h0000_0800);
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd5, 32'd0);

    // R11 R10 R5 masking and priority: 40 -> low bit 23, 10 -> low bit 6
    wr(3'd0, 32'd0); wr(3'd1, 32'd0);
    drive(40, 1'b0); drive(10, 1'b0); wait_edges(4);
    rd(3'd3, d); chk("R11 masked still pending", d, 32'h0080_0040);
    chk("R11 masked irq low", {31'd0, irq}, 32'd0);
    rd(3'd4, d); chk("R10 masked vector zero", d, 32'd0);
    wr(3'd1, 32'h0080_0000);
    rd(3'd4, d); chk("R10 only 40 enabled", d, 32'd40 << 26);
    chk("R11 irq enabled", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R10 lowest wins", d, 32'd10 << 26);
    wr(3'd3, 32'h0000_0040);
    rd(3'd3, d); chk("R5 set beats clear", d, 32'h0080_0040);
    drive(40, 1'b1); drive(10, 1'b1); wait_edges(4);
    wr(3'd3, 32'd0);
    rd(3'd3, d); chk("R5 write zero no effect", d, 32'h0080_0040);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R5 write ones clears", d, 32'd0);
    chk("R11 irq drops", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule